// File: doc/BRIEF.md
# Oversampled Nine-Bit Serial Receiver with Address Filtering

This block receives asynchronous serial frames of eleven bit times: a low start bit, eight data bits with the least significant bit first, a ninth bit, and a high stop bit. The serial line is brought through a two-flop synchroniser. It is then examined on a sample enable that pulses sixteen times per bit time. A falling edge while the block is idle starts a frame. Each bit is decided by a two-of-three vote taken in the middle of its bit time. A start bit that votes high is treated as noise, and the block goes back to idle.

Frame completion is tracked without a bit counter. A nine-bit shift register is preset to all ones when the frame starts. Voted bits enter it from the low end. The frame is complete when the zero of the start bit reaches the top position. At that sampling point a gate decides whether the frame is kept, and kept frames update the byte register, the ninth-bit register and a done flag. A frame is dropped when the done flag is still set from an earlier frame. It is also dropped when address filtering is on and its ninth bit is 0. Address filtering lets a node listen only for frames marked as addresses.

Top module: `mv_uart_rx`

## Requirements
- R1: While `rst` is high and after it falls, `rx_done`, `rx_byte` and `rx_bit9` are all 0.
- R2: A kept frame places data bit i (the i-th bit after the start bit, counting from 0) in `rx_byte[i]` and the bit after the eighth data bit in `rx_bit9`. One bit time is 16 pulses of `tick16`.
- R3: While idle, a 1-to-0 change of the synchronised line, seen on a `tick16` pulse, starts a frame. This restarts the bit-phase counter at 0 and presets the shift register to all ones.
- R4: Each bit is the majority of three samples taken on the `tick16` pulses at counter states 7, 8 and 9. A disturbance that reaches only one of the three samples does not change the bit. A disturbance that reaches two of them does change it.
- R5: If the start bit votes 1, the frame is abandoned, the outputs keep their values, and the block waits for the next falling edge.
- R6: Outputs change only at the sampling point of the ninth bit (counter state 9 of the tenth bit time). `rx_done` is still unchanged one `tick16` pulse before that point.
- R7: A frame that completes while `rx_done` is 1 is dropped, and `rx_byte`, `rx_bit9` and `rx_done` keep their values.
- R8: With `filt_en` high, a frame whose ninth bit is 0 is dropped without setting `rx_done`, and a frame whose ninth bit is 1 is kept. With `filt_en` low, both kinds are kept.
- R9: A one-cycle pulse on `done_clr` returns `rx_done` to 0 and leaves `rx_byte` and `rx_bit9` unchanged.
- R10: One bit time after the final sampling point the block is idle again, whether the frame was kept or dropped. A frame that follows a one-bit-time stop bit with no gap is therefore received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Sample enable, 16 pulses per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| filt_en | input | 1 | Keep only frames whose ninth bit is 1 |
| done_clr | input | 1 | Clears the done flag |
| rx_byte | output | 8 | Last kept data byte |
| rx_bit9 | output | 1 | Ninth bit of the last kept frame |
| rx_done | output | 1 | Set when a frame is kept |

## Verification
The bench drives every line change just after a `tick16` edge and holds each bit for 16 pulses. The start is detected on the next pulse, so the three vote samples see line intervals 8, 9 and 10 of each bit. Single-interval and double-interval disturbances are placed on that basis. Outputs are due on pulse 11 of the ninth-bit interval. The bench reads `rx_done` one pulse before that and one pulse after it. All other results are compared after the stop bit and an idle gap, when nothing can still be in flight.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_RECV = 2'd1,
    ST_TAIL = 2'd2
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mvrx_sync.sv
module mvrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], rx_i};
      if (tick) prev <= chain[STAGES-1];
    end
  end

  assign line_o = chain[STAGES-1];
  assign fall_o = tick & prev & ~chain[STAGES-1];

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/mvrx_vote.sv
module mvrx_vote
  import mvrx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          line,
  output logic          vld_o,
  output logic          bit_o
);

  localparam int MID = OVS / 2;

  logic samp_a, samp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (tick) begin
      if (cnt == CW'(MID - 1)) samp_a <= line;
      if (cnt == CW'(MID))     samp_b <= line;
    end
  end

  assign vld_o = tick && (cnt == CW'(MID + 1));
  assign bit_o = maj3(samp_a, samp_b, line);

  // R4
  vote_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_o && samp_a == samp_b) |-> (bit_o == samp_a));

endmodule

// File: rtl/mvrx_ctrl.sv
module mvrx_ctrl
  import mvrx_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          fall,
  input  logic          vld,
  input  logic          vbit,
  input  logic          filt_en,
  input  logic          done_clr,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          rx_done
);

  localparam int SRW = DW + 1;

  rx_state_t      st;
  logic [SRW-1:0] sr;
  logic [DW-1:0]  byte_rev;
  logic           first_bit, fin, accept, start_go;

  // Bits arrive least significant first, so the oldest data bit sits highest.
  always_comb begin
    for (int i = 0; i < DW; i++) byte_rev[i] = sr[DW-1-i];
  end

  assign start_go  = (st == ST_HUNT) && fall;
  assign first_bit = (sr == '1);
  assign fin       = (st == ST_RECV) && vld && !sr[SRW-1];
  assign accept    = !rx_done && (!filt_en || vbit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      sr      <= '1;
      rx_byte <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (done_clr) rx_done <= 1'b0;
      case (st)
        ST_HUNT: begin
          if (fall) begin
            st  <= ST_RECV;
            cnt <= '0;
            sr  <= '1;
          end
        end
        ST_RECV: begin
          if (tick) cnt <= cnt + 1'b1;
          if (vld) begin
            if (first_bit && vbit) begin
              st <= ST_HUNT;
            end else if (!sr[SRW-1]) begin
              st <= ST_TAIL;
              sr <= {sr[SRW-2:0], vbit};
              if (accept) begin
                rx_byte <= byte_rev;
                rx_bit9 <= vbit;
                rx_done <= 1'b1;
              end
            end else begin
              sr <= {sr[SRW-2:0], vbit};
            end
          end
        end
        ST_TAIL: begin
          if (tick) cnt <= cnt + 1'b1;
          if (vld) st <= ST_HUNT;
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (st == ST_RECV && cnt == '0 && sr == '1));

  // R6
  done_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> $past(fin));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && rx_done && !done_clr) |=> (rx_done && $stable(rx_byte) && $stable(rx_bit9)));

  // R8
  filt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && filt_en && !vbit && !done_clr) |=> (rx_done == $past(rx_done) && $stable(rx_byte)));

  // R5
  false_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECV && vld && first_bit && vbit) |=> (st == ST_HUNT && $stable(rx_done)));

endmodule

// File: rtl/mv_uart_rx.sv
module mv_uart_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              filt_en,
  input  logic              done_clr,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              rx_done
);

  localparam int CNT_W = $clog2(OVS);

  logic             line_s, fall_s, vote_vld, vote_bit;
  logic [CNT_W-1:0] phase;

  mvrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick16),
    .rx_i   (rx_in),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  mvrx_vote #(.OVS(OVS), .CW(CNT_W)) u_vote (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick16),
    .cnt   (phase),
    .line  (line_s),
    .vld_o (vote_vld),
    .bit_o (vote_bit)
  );

  mvrx_ctrl #(.DW(DATA_W), .CW(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick16),
    .fall     (fall_s),
    .vld      (vote_vld),
    .vbit     (vote_bit),
    .filt_en  (filt_en),
    .done_clr (done_clr),
    .cnt      (phase),
    .rx_byte  (rx_byte),
    .rx_bit9  (rx_bit9),
    .rx_done  (rx_done)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rx_done && rx_byte == '0 && !rx_bit9));

endmodule

// File: tb/mv_uart_rx_bench.sv
module mv_uart_rx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic       filt_en = 1'b0;
  logic       done_clr = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       rx_done;

  int total = 0;
  int fails = 0;
  logic [7:0] e_byte = 8'h00;
  logic       e_b9 = 1'b0;
  logic       e_done = 1'b0;
  logic       mon_pre, mon_post;
  int         tdiv = 0;

  mv_uart_rx u_mv_uart_rx (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
    .filt_en(filt_en), .done_clr(done_clr),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
    tick16 <= (tdiv == 3);
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) begin
      @(posedge clk);
      while (tick16 !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic [8:0] apply_glitch(input logic [8:0] v, input int gk, input int gl);
    logic [8:0] r = v;
    if (gl >= 2 && gk >= 1 && gk <= 9) r[gk-1] = ~r[gk-1];
    return r;
  endfunction

  task automatic model(input logic [8:0] v);
    if (!e_done && (!filt_en || v[8])) begin
      e_byte = v[7:0];
      e_b9   = v[8];
      e_done = 1'b1;
    end
  endtask

  // Glitch flips line intervals [gs, gs+gl) of bit gk; gl=0 means none.
  task automatic send_frame(input logic [7:0] d, input logic b9,
                            input int gk, input int gs, input int gl, input int idle);
    logic [10:0] bits;
    bits = {1'b1, b9, d, 1'b0};
    for (int k = 0; k < 11; k++) begin
      for (int j = 0; j < 16; j++) begin
        rx_in = bits[k] ^ ((k == gk) && (j >= gs) && (j < gs + gl));
        tk(1);
        if (k == 9 && j == 9)  mon_pre  = rx_done;
        if (k == 9 && j == 10) mon_post = rx_done;
      end
    end
    rx_in = 1'b1;
    if (idle > 0) tk(idle);
  endtask

  task automatic clear_done();
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    e_done = 1'b0;
    tk(1);
  endtask

  task automatic check_all(input string rq);
    chk(rq, {24'd0, rx_byte}, {24'd0, e_byte});
    chk(rq, {31'd0, rx_bit9}, {31'd0, e_b9});
    chk(rq, {31'd0, rx_done}, {31'd0, e_done});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (6) @(negedge clk);
    check_all("R1 during reset");
    rst = 1'b0;
    tk(20);
    check_all("R1 after reset");

    // R2 R3 R6: plain frame, filter off
    filt_en = 1'b0;
    send_frame(8'hA5, 1'b0, -1, 0, 0, 16);
    model({1'b0, 8'hA5});
    check_all("R2 R3 frame A5");
    chk("R6 done before final sample", {31'd0, mon_pre}, 32'd0);
    chk("R6 done at final sample", {31'd0, mon_post}, 32'd1);

    // R7: done still set
    send_frame(8'h3C, 1'b1, -1, 0, 0, 16);
    model({1'b1, 8'h3C});
    check_all("R7 unread drop");

    // R9: clear
    clear_done();
    check_all("R9 clear");

    // R8: filter on, ninth bit 0 dropped, then 1 kept
    filt_en = 1'b1;
    tk(1);
    send_frame(8'h5A, 1'b0, -1, 0, 0, 16);
    model({1'b0, 8'h5A});
    check_all("R8 data frame dropped");
    send_frame(8'h81, 1'b1, -1, 0, 0, 16);
    model({1'b1, 8'h81});
    check_all("R8 address frame kept");

    // R5: false start, line low for 3 intervals only
    clear_done();
    rx_in = 1'b0;
    tk(3);
    rx_in = 1'b1;
    tk(40);
    check_all("R5 false start");

    // R4: single-sample and two-sample disturbances
    filt_en = 1'b0;
    tk(1);
    send_frame(8'h00, 1'b0, 3, 9, 1, 16);
    model(apply_glitch({1'b0, 8'h00}, 3, 1));
    check_all("R4 one sample ignored");
    clear_done();
    send_frame(8'h00, 1'b0, 3, 8, 2, 16);
    model(apply_glitch({1'b0, 8'h00}, 3, 2));
    check_all("R4 two samples flip");
    chk("R4 flipped bit", {24'd0, rx_byte}, 32'h04);

    // R10: dropped frame then back-to-back kept frame
    clear_done();
    filt_en = 1'b1;
    tk(1);
    send_frame(8'h11, 1'b0, -1, 0, 0, 0);
    model({1'b0, 8'h11});
    send_frame(8'hE7, 1'b1, -1, 0, 0, 16);
    model({1'b1, 8'hE7});
    check_all("R10 back to back");

    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic       b9;
      int         gk, gl, gs;
      d  = 8'($urandom);
      b9 = 1'($urandom);
      if (($urandom % 3) != 0) clear_done();
      filt_en = 1'($urandom);
      tk(1);
      gl = $urandom % 3;
      gk = 1 + ($urandom % 9);
      gs = (gl == 2) ? 8 : 9;
      send_frame(d, b9, gk, gs, gl, (n % 4 == 0) ? 0 : 16);
      model(apply_glitch({b9, d}, gk, gl));
      if (n % 4 == 0) tk(16);
      check_all("R2 R4 R7 R8 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule